// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a synchronous burst memory port. A start strobe captures a full external address. From then on the low address bits walk through a short burst sequence that is generated inside the block, while the upper bits stay fixed. The default geometry has four beats, from a two-bit beat counter. The sequence moves forward only on cycles where the advance input is high. It can wrap around with an increment (linear order), or it can be the starting low bits XORed with the beat count (interleaved order).

There are two start strobes. The processor-side strobe counts only while the chip enable is high. The controller-side strobe always counts. If both count in the same cycle, the processor side takes the burst. Any cycle may load a fresh address with no idle cycle between bursts, so a user who never advances gets plain single-cycle addressing.

Every input is sampled on the rising clock edge. All outputs come from registers.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `addr_o` is 0, `burst_act_o` is 0, `beat_o` is 0 and `src_cpu_o` is 0.
- R2: A start at an edge loads `addr_i` and sets `beat_o` to 0 and `burst_act_o` to 1 from the next cycle on. This holds even if a burst is already running, which then ends. A start is either `cpu_start_i` with `chip_en_i` high, or `ctl_start_i`.
- R3: When both strobes count at the same edge, the processor side wins, and `src_cpu_o` becomes 1. `src_cpu_o` is 0 for a burst opened by the controller-side strobe.
- R4: When `chip_en_i` is low, `cpu_start_i` has no effect. With no other start, the outputs carry on exactly as if the strobe were low.
- R5: If `order_lin_i` is 1 at the start, the two low address bits equal (captured low bits + `beat_o`) mod 4.
- R6: If `order_lin_i` is 0 at the start, the two low address bits equal the captured low bits XOR `beat_o`. Tie `order_lin_i` to 0 when it is not driven, so the default order is interleaved.
- R7: The order is latched at the start. Changes on `order_lin_i` during a burst have no effect on the sequence.
- R8: During a burst, an edge with `adv_i` high and no start raises `beat_o` by one. An edge with `adv_i` low and no start holds `addr_o` and `beat_o`.
- R9: The address bits above the two low bits never change while a burst runs, except through a new start.
- R10: An advance at beat 3 ends the burst: `burst_act_o` goes to 0, and `beat_o` and `addr_o` hold. `adv_i` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address to capture |
| cpu_start_i | input | 1 | Processor-side start strobe, gated by `chip_en_i` |
| chip_en_i | input | 1 | Chip enable for the processor-side strobe |
| ctl_start_i | input | 1 | Controller-side start strobe |
| adv_i | input | 1 | Step the burst by one beat |
| order_lin_i | input | 1 | 1 linear, 0 interleaved; sampled at start |
| addr_o | output | ADDR_W | Current array address |
| burst_act_o | output | 1 | A burst is in progress |
| beat_o | output | BEAT_W | Current beat index |
| src_cpu_o | output | 1 | Current burst was opened by the processor side |

## Verification
The assertions assume that every input is settled and known at each rising edge. They also assume that reset is released away from an edge, because every property reads the previous cycle's inputs through `$past`. The bench drives all inputs at the falling edge, so they stay stable across the sampling edge. It releases reset between edges as well. Directed phases set up the strobe collisions, order changes in mid-burst, advance gaps and idle advances. A long random phase then mixes all of these freely.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic {SRC_CTL = 1'b0, SRC_CPU = 1'b1} bst_src_e;

  typedef struct packed {
    logic     go;
    bst_src_e src;
  } bst_start_t;
endpackage

// File: rtl/bst_start_arb.sv
module bst_start_arb
  import bst_pkg::*;
(
  input  logic       cpu_start_i,
  input  logic       chip_en_i,
  input  logic       ctl_start_i,
  output bst_start_t start_o
);
  logic cpu_ok;
  assign cpu_ok       = cpu_start_i & chip_en_i;
  assign start_o.go   = cpu_ok | ctl_start_i;
  assign start_o.src  = cpu_ok ? SRC_CPU : SRC_CTL;
endmodule

// File: rtl/bst_beat_ctr.sv
module bst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              act_o
);
  localparam logic [BEAT_W-1:0] LastBeat = {BEAT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o <= '0;
      act_o  <= 1'b0;
    end else if (start_i) begin
      beat_o <= '0;
      act_o  <= 1'b1;
    end else if (act_o && adv_i) begin
      if (beat_o == LastBeat) act_o  <= 1'b0;
      else                    beat_o <= beat_o + 1'b1;
    end
  end

  p_last_beat_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && adv_i && !start_i && beat_o == LastBeat) |=> (!act_o && $stable(beat_o)));

  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && adv_i && !start_i && beat_o != LastBeat) |=> (act_o && beat_o == $past(beat_o) + 1'b1));

  p_idle_adv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_o && !start_i) |=> (!act_o && $stable(beat_o)));
endmodule

// File: rtl/bst_addr_gen.sv
module bst_addr_gen
  import bst_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bst_start_t        start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_lin_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              src_cpu_o
);
  localparam int UpW = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic              lin_q;
  bst_src_e          src_q;
  logic [BEAT_W-1:0] low_lin, low_il, low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      lin_q  <= 1'b0;
      src_q  <= SRC_CTL;
    end else if (start_i.go) begin
      base_q <= addr_i;
      lin_q  <= order_lin_i;
      src_q  <= start_i.src;
    end
  end

  assign low_lin = base_q[BEAT_W-1:0] + beat_i;
  assign low_il  = base_q[BEAT_W-1:0] ^ beat_i;
  assign low     = lin_q ? low_lin : low_il;

  generate
    if (UpW > 0) begin : g_upper
      assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};
    end else begin : g_low_only
      assign addr_o = low;
    end
  endgenerate

  assign src_cpu_o = (src_q == SRC_CPU);

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i.go |=> (addr_o == $past(addr_i) && beat_i == '0));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bst_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_start_i,
  input  logic              chip_en_i,
  input  logic              ctl_start_i,
  input  logic              adv_i,
  input  logic              order_lin_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_act_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              src_cpu_o
);
  bst_start_t start;

  bst_start_arb u_arb (
    .cpu_start_i(cpu_start_i),
    .chip_en_i  (chip_en_i),
    .ctl_start_i(ctl_start_i),
    .start_o    (start)
  );

  bst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start.go),
    .adv_i  (adv_i),
    .beat_o (beat_o),
    .act_o  (burst_act_o)
  );

  bst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (addr_i),
    .order_lin_i(order_lin_i),
    .beat_i     (beat_o),
    .addr_o     (addr_o),
    .src_cpu_o  (src_cpu_o)
  );

  p_cpu_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_start_i && chip_en_i) |=> (src_cpu_o && burst_act_o));

  p_ctl_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_start_i && !(cpu_start_i && chip_en_i)) |=> !src_cpu_o);

  p_gated_cpu_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_start_i && !chip_en_i && !ctl_start_i && !adv_i) |=>
      ($stable(addr_o) && $stable(burst_act_o) && $stable(src_cpu_o)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_act_o && !adv_i && !ctl_start_i && !(cpu_start_i && chip_en_i)) |=>
      ($stable(addr_o) && $stable(beat_o)));

  p_upper_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_act_o && !ctl_start_i && !(cpu_start_i && chip_en_i)) |=>
      $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 19;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_s = 1'b0, ce = 1'b0, ctl_s = 1'b0, adv = 1'b0, lin = 1'b0;
  logic [AW-1:0] addr_out;
  logic          act_out, src_out;
  logic [BW-1:0] beat_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int m_base = 0, m_beat = 0, m_act = 0, m_lin = 0, m_src = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_in), .cpu_start_i(cpu_s),
    .chip_en_i(ce), .ctl_start_i(ctl_s), .adv_i(adv), .order_lin_i(lin),
    .addr_o(addr_out), .burst_act_o(act_out), .beat_o(beat_out), .src_cpu_o(src_out)
  );

  function automatic int exp_addr();
    int low;
    if (m_lin != 0) low = ((m_base & 3) + m_beat) & 3;
    else            low = (m_base & 3) ^ m_beat;
    return (m_base & ~3) | low;
  endfunction

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("addr", int'(addr_out), exp_addr());
    chk("act", int'(act_out), m_act);
    chk("beat", int'(beat_out), m_beat);
    chk("src", int'(src_out), m_src);
  endtask

  // one cycle: inputs already set at negedge; model steps at posedge
  task automatic step(input int a, input bit c, input bit e, input bit t,
                      input bit v, input bit l);
    bit cpu_ok;
    addr_in = AW'(a); cpu_s = c; ce = e; ctl_s = t; adv = v; lin = l;
    @(posedge clk);
    cpu_ok = c && e;
    if (cpu_ok || t) begin
      m_base = a & ((1 << AW) - 1); m_beat = 0; m_act = 1;
      m_lin = l; m_src = cpu_ok ? 1 : 0;
    end else if (m_act != 0 && v) begin
      if (m_beat == 3) m_act = 0;
      else m_beat = m_beat + 1;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    compare();
    #3 rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R5 linear burst from low bits 2
    cur_req = "R5";
    step('h12346, 0, 0, 1, 0, 1);
    repeat (4) step(0, 0, 0, 0, 1, 1);

    // R6 interleaved burst from low bits 1, then 3
    cur_req = "R6";
    step('h0abc1, 0, 0, 1, 0, 0);
    repeat (4) step(0, 0, 0, 0, 1, 0);
    step('h7ff3, 0, 1, 1, 0, 0);
    repeat (3) step(0, 0, 0, 0, 1, 0);

    // R3 both strobes at once; then controller alone
    cur_req = "R3";
    step('h55555, 1, 1, 1, 0, 1);
    step('h22222, 0, 0, 1, 0, 1);

    // R4 gated processor strobe, with and without advance
    cur_req = "R4";
    step('h11111, 1, 0, 0, 0, 1);
    step('h33333, 1, 0, 0, 1, 1);
    step('h44444, 1, 0, 0, 0, 1);

    // R7 order toggled mid-burst
    cur_req = "R7";
    step('h00003, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);

    // R8 and R9 advance gaps
    cur_req = "R8";
    step('h7fffe, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0);
    cur_req = "R9";
    step(0, 0, 0, 0, 1, 0);

    // R10 burst end and idle advance
    cur_req = "R10";
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1);

    // R2 restart mid-burst, back-to-back loads
    cur_req = "R2";
    step('h10001, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step('h20002, 1, 1, 0, 0, 1);
    step('h30003, 0, 0, 1, 1, 0);
    step('h40000, 1, 1, 0, 1, 1);

    // random mix across all requirements
    cur_req = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step($urandom, (r & 7) == 0, r[3], (r & 48) == 0, r[6] | r[7], r[8]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule